// File: doc/BRIEF.md
# Store-Multiple-Word Sequencer

This block is a small multi-cycle controller placed beside a load/store unit. Given a first register number, it copies every general-purpose register from that number up to register 31 into consecutive 32-bit memory words. A single start pulse supplies the first register number, a base value with a flag saying the base register index is zero, and a signed 16-bit displacement. From these the block forms the first byte address.

For each register the block reads the register file through a one-port synchronous read interface. It then offers the low 32 bits of the returned value on a valid/ready write port, together with the current address. The register number and the address advance after every accepted write, and a one-cycle done pulse marks the end of the run.

The block has no exception, misalignment or status-flag side effects. It reports only busy and done.

Top module: `multi_word_store`

## Requirements
- R1: The first write address is `B + sext(disp_i)`, modulo 2^ADDR_W. B is `base_val_i`, or 0 when `base_zero_i` is 1. `disp_i` is a 16-bit two's-complement value.
- R2: Writes cover registers `start_reg_i`, `start_reg_i`+1, ... up to 31, in that order. The write count is exactly 32 − `start_reg_i`.
- R3: The data of each write is bits [31:0] (the low word) of the 64-bit value read for that register.
- R4: Each accepted write after the first in a run has an address 4 greater than the previous one, wrapping modulo 2^ADDR_W.
- R5: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` stay unchanged into the next cycle.
- R6: For each word, `rf_rd_en_o` is high for exactly one cycle with `rf_rd_idx_o` equal to that word's register. `rf_rd_data_i` is taken in the following cycle. `rf_rd_en_o` is never high together with `wr_valid_o`.
- R7: `busy_o` rises in the cycle after an accepted start pulse and stays high up to and including the done cycle. A start pulse while `busy_o` is high is ignored and does not change the run.
- R8: `done_o` is high for exactly one cycle, the cycle right after the final write handshake. `busy_o` and `done_o` are both low in the cycle after that.
- R9: During and after reset, with no start pulse, `busy_o`, `done_o`, `wr_valid_o` and `rf_rd_en_o` are low.
- R10: A start register of 31 produces exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| start_reg_i | input | IDX_W (5) | First register number |
| base_zero_i | input | 1 | Base register index is zero; use 0 as base |
| base_val_i | input | ADDR_W (64) | Base register value |
| disp_i | input | DISP_W (16) | Signed byte displacement |
| rf_rd_en_o | output | 1 | Register read request |
| rf_rd_idx_o | output | IDX_W (5) | Register number to read |
| rf_rd_data_i | input | REG_W (64) | Read data, valid the cycle after the request |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_addr_o | output | ADDR_W (64) | Byte address of the word |
| wr_data_o | output | WORD_W (32) | Word to store |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Several properties are checked in every cycle of every run: the write port holds still under back-pressure, consecutive addresses step by four, done is a single cycle that follows a handshake, busy rises and falls around a run, and reads never overlap writes. Only the bench's scenarios can show the rest. These are the correct first address for zero-base, negative-displacement and wrapping cases, the low-word data of each register, the exact write count for start registers 0, 25, 28, 29, 30 and 31, and that a start pulse arriving mid-run leaves the sequence untouched.

// File: rtl/mws_pkg.sv
package mws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } mws_state_e;
endpackage

// File: rtl/mws_ea_gen.sv
module mws_ea_gen #(
   parameter int ADDR_W = 64,
   parameter int DISP_W = 16,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic              base_zero,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] addr_q
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] base_eff;

   generate
      if (DISP_W > ADDR_W) begin : g_bad_disp
         $error("mws_ea_gen: DISP_W must not exceed ADDR_W");
      end
      if (DISP_W < ADDR_W) begin : g_sext
         assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      end else begin : g_full
         assign disp_ext = disp;
      end
   endgenerate

   assign base_eff = base_zero ? '0 : base_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= base_eff + disp_ext;
      end else if (advance) begin
         addr_q <= addr_q + STEP_V;
      end
   end
endmodule

// File: rtl/mws_word_lane.sv
module mws_word_lane #(
   parameter int REG_W  = 64,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [REG_W-1:0]  reg_data,
   output logic [WORD_W-1:0] word_q
);
   logic [WORD_W-1:0] low_word;

   generate
      if (WORD_W > REG_W) begin : g_bad_word
         $error("mws_word_lane: WORD_W must not exceed REG_W");
      end
      if (WORD_W == REG_W) begin : g_whole
         assign low_word = reg_data;
      end else begin : g_slice
         logic unused_hi;
         assign low_word  = reg_data[WORD_W-1:0];
         assign unused_hi = ^reg_data[REG_W-1:WORD_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (capture) begin
         word_q <= low_word;
      end
   end
endmodule

// File: rtl/mws_ctrl.sv
module mws_ctrl
   import mws_pkg::*;
#(
   parameter int IDX_W    = 5,
   parameter int LAST_REG = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] start_reg,
   input  logic             wr_ready,
   output logic [IDX_W-1:0] idx_q,
   output logic             rd_en,
   output logic             load,
   output logic             capture,
   output logic             advance,
   output logic             wr_valid,
   output logic             busy,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST_V = IDX_W'(LAST_REG);

   generate
      if (LAST_REG >= (1 << IDX_W)) begin : g_bad_last
         $error("mws_ctrl: LAST_REG does not fit in IDX_W bits");
      end
   endgenerate

   mws_state_e state_q;
   logic       wait_q;
   logic       last_w;

   assign last_w   = (idx_q == LAST_V);
   assign load     = (state_q == ST_IDLE) && start;
   assign rd_en    = (state_q == ST_READ) && !wait_q;
   assign capture  = (state_q == ST_READ) && wait_q;
   assign wr_valid = (state_q == ST_WRITE);
   assign advance  = wr_valid && wr_ready && !last_w;
   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         wait_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  idx_q   <= start_reg;
                  wait_q  <= 1'b0;
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (!wait_q) begin
                  wait_q <= 1'b1;
               end else begin
                  wait_q  <= 1'b0;
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (wr_ready) begin
                  if (last_w) begin
                     state_q <= ST_DONE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_READ;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/multi_word_store.sv
module multi_word_store #(
   parameter int REG_W    = 64,
   parameter int WORD_W   = 32,
   parameter int ADDR_W   = 64,
   parameter int DISP_W   = 16,
   parameter int IDX_W    = 5,
   parameter int LAST_REG = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  start_reg_i,
   input  logic              base_zero_i,
   input  logic [ADDR_W-1:0] base_val_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic              rf_rd_en_o,
   output logic [IDX_W-1:0]  rf_rd_idx_o,
   input  logic [REG_W-1:0]  rf_rd_data_i,
   output logic              wr_valid_o,
   input  logic              wr_ready_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int STEP = WORD_W / 8;

   generate
      if ((WORD_W % 8) != 0) begin : g_bad_bytes
         $error("multi_word_store: WORD_W must be a whole number of bytes");
      end
   endgenerate

   logic load_w;
   logic capture_w;
   logic advance_w;

   mws_ctrl #(
      .IDX_W    (IDX_W),
      .LAST_REG (LAST_REG)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .start_reg (start_reg_i),
      .wr_ready  (wr_ready_i),
      .idx_q     (rf_rd_idx_o),
      .rd_en     (rf_rd_en_o),
      .load      (load_w),
      .capture   (capture_w),
      .advance   (advance_w),
      .wr_valid  (wr_valid_o),
      .busy      (busy_o),
      .done      (done_o)
   );

   mws_ea_gen #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W),
      .STEP   (STEP)
   ) u_ea (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_w),
      .advance   (advance_w),
      .base_zero (base_zero_i),
      .base_val  (base_val_i),
      .disp      (disp_i),
      .addr_q    (wr_addr_o)
   );

   mws_word_lane #(
      .REG_W  (REG_W),
      .WORD_W (WORD_W)
   ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture_w),
      .reg_data (rf_rd_data_i),
      .word_q   (wr_data_o)
   );
endmodule

// File: rtl/mws_checker.sv
module mws_checker #(
   parameter int ADDR_W = 64,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              rf_rd_en_o,
   input logic              wr_valid_o,
   input logic              wr_ready_i,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [WORD_W-1:0] wr_data_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(WORD_W / 8);

   logic [ADDR_W-1:0] next_addr_q;
   logic              armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q     <= 1'b0;
         next_addr_q <= '0;
      end else if (done_o) begin
         armed_q <= 1'b0;
      end else if (wr_valid_o && wr_ready_i) begin
         armed_q     <= 1'b1;
         next_addr_q <= wr_addr_o + STEP_V;
      end
   end

   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && armed_q) |-> (wr_addr_o == next_addr_q));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(wr_valid_o && wr_ready_i));

   // R7
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R7
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o ##1 !busy_o);

   // R6
   read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_rd_en_o |-> (busy_o && !wr_valid_o));
endmodule

bind multi_word_store mws_checker #(
   .ADDR_W (ADDR_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .rf_rd_en_o (rf_rd_en_o),
   .wr_valid_o (wr_valid_o),
   .wr_ready_i (wr_ready_i),
   .wr_addr_o  (wr_addr_o),
   .wr_data_o  (wr_data_o)
);

// File: tb/multi_word_store_test.sv
`timescale 1ns/1ps
module multi_word_store_test;
   typedef struct packed {
      logic [4:0]  sr;
      logic        zero;
      logic [63:0] base;
      logic [15:0] disp;
      logic [63:0] exp_addr;
      logic        stall;
      logic        poke;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{5'd28, 1'b0, 64'h0000_0000_0001_0000, 16'h0010, 64'h0000_0000_0001_0010, 1'b0, 1'b0},
      '{5'd25, 1'b1, 64'hFFFF_0000_1234_5678, 16'h0100, 64'h0000_0000_0000_0100, 1'b1, 1'b0},
      '{5'd30, 1'b0, 64'h0000_0000_0000_2000, 16'hFFF0, 64'h0000_0000_0000_1FF0, 1'b0, 1'b1},
      '{5'd31, 1'b0, 64'h0000_0000_8000_0000, 16'h8000, 64'h0000_0000_7FFF_8000, 1'b1, 1'b0},
      '{5'd0,  1'b0, 64'h0000_0000_0004_0000, 16'h0004, 64'h0000_0000_0004_0004, 1'b0, 1'b0},
      '{5'd29, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0000, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [4:0]  start_reg_i = '0;
   logic        base_zero_i = 1'b0;
   logic [63:0] base_val_i = '0;
   logic [15:0] disp_i = '0;
   logic        rf_rd_en_o;
   logic [4:0]  rf_rd_idx_o;
   logic [63:0] rf_rd_data_i = '0;
   logic        wr_valid_o;
   logic        wr_ready_i = 1'b1;
   logic [63:0] wr_addr_o;
   logic [31:0] wr_data_o;
   logic        busy_o;
   logic        done_o;

   int   checks = 0;
   int   fails = 0;
   int   cyc = 0;
   logic stall_mode = 1'b0;
   logic [63:0] regs [32];

   always #4 clk = ~clk;

   multi_word_store uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_reg_i(start_reg_i),
      .base_zero_i(base_zero_i), .base_val_i(base_val_i), .disp_i(disp_i),
      .rf_rd_en_o(rf_rd_en_o), .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_data_i(rf_rd_data_i),
      .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o)
   );

   // register file model: one-cycle synchronous read
   always @(posedge clk) begin
      if (rf_rd_en_o) rf_rd_data_i <= regs[rf_rd_idx_o];
   end

   // memory acceptance pattern
   initial begin
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         wr_ready_i = !stall_mode || (cyc % 3 == 0);
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic fill_regs(input int seed);
      for (int i = 0; i < 32; i++) begin
         regs[i] = {32'hFEED_0000 | 32'(i), (32'h3C00_0000 ^ (32'(i) << 16)) ^ (32'(seed) * 32'h0100_0193)};
      end
   endtask

   task automatic run_op(input vec_t v, input int seed);
      int  k = 0;
      int  rd_k = 0;
      int  ncyc = 0;
      int  last_hs = -10;
      bit  first = 1;
      bit  hold_pend = 0;
      bit  poked = 0;
      bit  finished = 0;
      logic [63:0] h_addr = '0;
      logic [31:0] h_data = '0;
      logic [63:0] exp_a;
      fill_regs(seed);
      stall_mode = v.stall;
      @(posedge clk); #1;
      start_i = 1'b1; start_reg_i = v.sr; base_zero_i = v.zero;
      base_val_i = v.base; disp_i = v.disp;
      @(posedge clk); #1;
      start_i = 1'b0;
      for (int g = 0; g < 3000 && !finished; g++) begin
         @(negedge clk);
         ncyc++;
         if (poked) begin
            start_i = 1'b0;
         end
         if (first) begin
            check(busy_o == 1'b1, "R7 busy after start", 64'(busy_o), 64'd1);
            first = 0;
         end
         if (rf_rd_en_o) begin
            check(32'(rf_rd_idx_o) == 32'(v.sr) + 32'(rd_k), "R6 read index",
                  64'(rf_rd_idx_o), 64'(32'(v.sr) + 32'(rd_k)));
            rd_k++;
         end
         if (hold_pend) begin
            check(wr_valid_o && wr_addr_o == h_addr && wr_data_o == h_data, "R5 hold under stall",
                  wr_addr_o, h_addr);
            hold_pend = 0;
         end
         if (wr_valid_o) begin
            if (!wr_ready_i) begin
               hold_pend = 1; h_addr = wr_addr_o; h_data = wr_data_o;
            end else begin
               exp_a = v.exp_addr + 64'(4 * k);
               check(wr_addr_o == exp_a, (k == 0) ? "R1 first address" : "R4 address step",
                     wr_addr_o, exp_a);
               check(wr_data_o == regs[32'(v.sr) + k][31:0], "R3 low word data",
                     64'(wr_data_o), 64'(regs[32'(v.sr) + k][31:0]));
               last_hs = ncyc;
               k++;
               if (v.poke && !poked) begin
                  start_i = 1'b1; start_reg_i = 5'd0;
                  poked = 1;
               end
            end
         end
         if (done_o) begin
            check(ncyc == last_hs + 1, "R8 done follows last handshake",
                  64'(ncyc), 64'(last_hs + 1));
            check(k == 32 - int'(v.sr), (v.sr == 5'd31) ? "R10 single write" : "R2 write count",
                  64'(k), 64'(32 - int'(v.sr)));
            finished = 1;
         end
      end
      start_i = 1'b0;
      check(finished == 1'b1, "R8 done seen", 64'(finished), 64'd1);
      @(negedge clk);
      check(!done_o && !busy_o, "R8 idle after done", {62'd0, busy_o, done_o}, 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      fill_regs(0);
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && !wr_valid_o && !rf_rd_en_o, "R9 reset outputs",
            {60'd0, busy_o, done_o, wr_valid_o, rf_rd_en_o}, 64'd0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy_o && !done_o && !wr_valid_o && !rf_rd_en_o, "R9 idle after reset",
            {60'd0, busy_o, done_o, wr_valid_o, rf_rd_en_o}, 64'd0);

      for (int n = 0; n < NV; n++) begin
         run_op(VECS[n], n + 1);
      end

      // directed: single-word run with a start pulse held through it (R7, R10)
      run_op('{5'd31, 1'b1, 64'h1234, 16'hFFFC, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b1}, 9);

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule